// File: doc/BRIEF.md
# Low-Power PWM Timer

A single-channel pulse-width modulation timer programmed through a small 16-bit register bus. A power-of-two prescaler divides the system clock into counter ticks. A free-running counter steps from zero up to a reload limit and then wraps. The output is driven high (before polarity) while the count is above a compare threshold. So the period is set by the reload value and the high time by the gap between reload and compare.

The registers follow access rules that depend on the enable state. The prescaler and polarity settings can be changed only while the timer is disabled. The reload and compare values can be written only while it is enabled. Every accepted reload or compare write raises a sticky acknowledge flag. Software clears these flags through a separate write-one-to-clear register. Reload and compare updates made while the counter runs are held until the next wrap, so no period is cut short.

Software enables the timer, writes reload and compare, waits for both acknowledge flags, and then sets the start bit to run the counter continuously. Writing zero to the control register stops the counter and forces the output to its idle level.

Top module: `lp_pwm_timer`

## Requirements
- R1: After reset every register reads 0 and `pwm_out` is 0.
- R2: The setup register at 0x04 (bits 2:0 prescaler exponent, bit 3 polarity) takes a write only while the enable bit is 0. A write made while enabled leaves its readback unchanged.
- R3: The reload register at 0x08 and the compare register at 0x0C take writes only while enabled. A write made while disabled changes neither the readback nor any flag.
- R4: The flag register at 0x10 sets bit 1 (reload acknowledged) or bit 0 (compare acknowledged) one clock after an accepted write to the matching register, and the bit stays set until it is cleared.
- R5: Writing 1 to a bit of the clear register at 0x14 clears the matching flag. A 0 bit leaves its flag unchanged, and the clear register always reads 0.
- R6: Control register 0x00 holds enable at bit 0 and run at bit 2. A write with bit 2 set starts the counter only if enable is already 1 and bit 0 of the write is 1; otherwise the run bit stays 0. The counter starts from 0 and counts one per tick.
- R7: The counter wraps to 0 after it reaches the reload value. The output period is (reload+1)·2^presc clock cycles.
- R8: Before polarity, the output is low while count ≤ compare and high while count > compare. This gives (reload−compare)·2^presc high cycles per period, and none when compare ≥ reload.
- R9: The polarity bit inverts the output. While the counter is not running, the output sits at the idle level, which equals the polarity bit.
- R10: Writing 0 to control clears enable and run, forces the idle level at once, and makes the next start begin again from count 0.
- R11: Reload and compare values written while running take effect only at the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 1 | Waveform output |

## Verification
The assertions check on every cycle that the setup fields stay frozen while enabled, and that reload and compare stay frozen while disabled. They also check that the run state implies enable, that the count never passes the active reload limit, that each acknowledge flag rises only two edges after an accepted bus write, and that the output sits at the idle level whenever the counter is stopped. Only the bench scenarios can show the waveform arithmetic: the measured period and high time across a sweep of prescaler, reload, compare and polarity values. They also cover the exact phase of the output after a start, the deferral of a compare update to the wrap, and restart from zero after a stop.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_SETUP = 8'h04;
    localparam logic [7:0] OFS_RELOD = 8'h08;
    localparam logic [7:0] OFS_THRSH = 8'h0C;
    localparam logic [7:0] OFS_FLAGS = 8'h10;
    localparam logic [7:0] OFS_FCLR  = 8'h14;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_RUN_BIT   = 2;
    localparam int SETUP_POL_BIT  = 3;
    localparam int FLAG_THRSH_BIT = 0;
    localparam int FLAG_RELOD_BIT = 1;
endpackage

// File: rtl/lpt_regfile.sv
module lpt_regfile #(
    parameter int DW = 16,
    parameter int AW = 5,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          en,
    output logic          run,
    output logic [PW-1:0] presc,
    output logic          pol,
    output logic [DW-1:0] relod,
    output logic [DW-1:0] thrsh,
    output logic          relod_ok,
    output logic          thrsh_ok
);
    import lpt_pkg::*;

    typedef struct packed {
        logic          en;
        logic          run;
        logic [PW-1:0] presc;
        logic          pol;
        logic [DW-1:0] relod;
        logic [DW-1:0] thrsh;
        logic          relod_wr;
        logic          thrsh_wr;
        logic          relod_ok;
        logic          thrsh_ok;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit_ctrl, hit_setup, hit_relod, hit_thrsh, hit_fclr;

    always_comb begin
        hit_ctrl  = we && (addr == OFS_CTRL[AW-1:0]);
        hit_setup = we && (addr == OFS_SETUP[AW-1:0]);
        hit_relod = we && (addr == OFS_RELOD[AW-1:0]);
        hit_thrsh = we && (addr == OFS_THRSH[AW-1:0]);
        hit_fclr  = we && (addr == OFS_FCLR[AW-1:0]);

        r_d = r_q;
        r_d.relod_wr = 1'b0;
        r_d.thrsh_wr = 1'b0;

        if (hit_ctrl) begin
            r_d.en  = wdata[CTRL_EN_BIT];
            r_d.run = wdata[CTRL_EN_BIT] && r_q.en &&
                      (wdata[CTRL_RUN_BIT] || r_q.run);
        end
        if (hit_setup && !r_q.en) begin
            r_d.presc = wdata[PW-1:0];
            r_d.pol   = wdata[SETUP_POL_BIT];
        end
        if (hit_relod && r_q.en) begin
            r_d.relod    = wdata;
            r_d.relod_wr = 1'b1;
        end
        if (hit_thrsh && r_q.en) begin
            r_d.thrsh    = wdata;
            r_d.thrsh_wr = 1'b1;
        end

        r_d.relod_ok = (r_q.relod_ok && !(hit_fclr && wdata[FLAG_RELOD_BIT])) || r_q.relod_wr;
        r_d.thrsh_ok = (r_q.thrsh_ok && !(hit_fclr && wdata[FLAG_THRSH_BIT])) || r_q.thrsh_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_CTRL[AW-1:0]) begin
            rdata[CTRL_EN_BIT]  = r_q.en;
            rdata[CTRL_RUN_BIT] = r_q.run;
        end else if (addr == OFS_SETUP[AW-1:0]) begin
            rdata[PW-1:0]          = r_q.presc;
            rdata[SETUP_POL_BIT]   = r_q.pol;
        end else if (addr == OFS_RELOD[AW-1:0]) begin
            rdata = r_q.relod;
        end else if (addr == OFS_THRSH[AW-1:0]) begin
            rdata = r_q.thrsh;
        end else if (addr == OFS_FLAGS[AW-1:0]) begin
            rdata[FLAG_RELOD_BIT] = r_q.relod_ok;
            rdata[FLAG_THRSH_BIT] = r_q.thrsh_ok;
        end
    end

    assign en       = r_q.en;
    assign run      = r_q.run;
    assign presc    = r_q.presc;
    assign pol      = r_q.pol;
    assign relod    = r_q.relod;
    assign thrsh    = r_q.thrsh;
    assign relod_ok = r_q.relod_ok;
    assign thrsh_ok = r_q.thrsh_ok;
endmodule

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] presc,
    output logic          tick
);
    localparam int DIVW = 1 << PW;

    typedef struct packed {
        logic [DIVW-1:0] cnt;
    } pre_t;

    pre_t            p_d, p_q;
    logic [DIVW-1:0] one_sh;
    logic [DIVW-1:0] limit;

    always_comb begin
        one_sh = {{(DIVW-1){1'b0}}, 1'b1} << presc;
        limit  = one_sh - 1'b1;
        tick   = run && (p_q.cnt == limit);
        p_d    = p_q;
        if (!run)      p_d.cnt = '0;
        else if (tick) p_d.cnt = '0;
        else           p_d.cnt = p_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [DW-1:0] relod,
    input  logic [DW-1:0] thrsh,
    output logic [DW-1:0] count,
    output logic [DW-1:0] act_relod,
    output logic          active
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] lim;
        logic [DW-1:0] cmp;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!run) begin
            c_d.cnt = '0;
            c_d.lim = relod;
            c_d.cmp = thrsh;
        end else if (tick) begin
            if (c_q.cnt >= c_q.lim) begin
                c_d.cnt = '0;
                c_d.lim = relod;
                c_d.cmp = thrsh;
            end else begin
                c_d.cnt = c_q.cnt + 1'b1;
            end
        end
        active = run && (c_q.cnt > c_q.cmp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count     = c_q.cnt;
    assign act_relod = c_q.lim;
endmodule

// File: rtl/lp_pwm_timer.sv
module lp_pwm_timer #(
    parameter int DW = 16,
    parameter int AW = 5,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          pwm_out
);
    logic          en_w, run_w, pol_w, tick_w, active_w;
    logic          relod_ok_w, thrsh_ok_w;
    logic [PW-1:0] presc_w;
    logic [DW-1:0] relod_w, thrsh_w, count_w, act_relod_w;

    lpt_regfile #(.DW(DW), .AW(AW), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .en(en_w), .run(run_w),
        .presc(presc_w), .pol(pol_w), .relod(relod_w), .thrsh(thrsh_w),
        .relod_ok(relod_ok_w), .thrsh_ok(thrsh_ok_w)
    );

    lpt_prescaler #(.PW(PW)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_w), .presc(presc_w), .tick(tick_w)
    );

    lpt_counter #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run_w), .tick(tick_w),
        .relod(relod_w), .thrsh(thrsh_w), .count(count_w),
        .act_relod(act_relod_w), .active(active_w)
    );

    assign pwm_out = pol_w ^ active_w;
endmodule

// File: rtl/lp_pwm_timer_checker.sv
module lp_pwm_timer_checker #(
    parameter int DW = 16,
    parameter int AW = 5,
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic          en,
    input logic          run,
    input logic [PW-1:0] presc,
    input logic          pol,
    input logic [DW-1:0] relod,
    input logic [DW-1:0] thrsh,
    input logic [DW-1:0] count,
    input logic [DW-1:0] act_relod,
    input logic          relod_ok,
    input logic          thrsh_ok,
    input logic          pwm_out
);
    import lpt_pkg::*;

    AST_SETUP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) |-> ($stable(presc) && $stable(pol))); // R2
    AST_VALUES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> ($stable(relod) && $stable(thrsh))); // R3
    AST_RELOD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(relod_ok) |-> $past(bus_we && (bus_addr == OFS_RELOD[AW-1:0]) && en, 2)); // R4
    AST_THRSH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thrsh_ok) |-> $past(bus_we && (bus_addr == OFS_THRSH[AW-1:0]) && en, 2)); // R4
    AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> en); // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (count <= act_relod)); // R7
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm_out == pol)); // R9
endmodule

bind lp_pwm_timer lp_pwm_timer_checker #(.DW(DW), .AW(AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .en(en_w), .run(run_w), .presc(presc_w), .pol(pol_w),
    .relod(relod_w), .thrsh(thrsh_w), .count(count_w),
    .act_relod(act_relod_w), .relod_ok(relod_ok_w), .thrsh_ok(thrsh_ok_w),
    .pwm_out(pwm_out)
);

// File: tb/lp_pwm_timer_test.sv
module lp_pwm_timer_test;
    localparam int A_CTRL = 'h00, A_SETUP = 'h04, A_RELOD = 'h08;
    localparam int A_THRSH = 'h0C, A_FLAGS = 'h10, A_FCLR = 'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pwm_out;
    int          n_chk = 0;
    int          n_fail = 0;

    lp_pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr  = a[4:0];
        bus_wdata = d[15:0];
        bus_we    = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_addr = a[4:0];
        #1 d = int'(bus_rdata);
    endtask

    task automatic measure_period(input int pol, output int per);
        int prev, cur, n;
        per = -1;
        prev = 1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            cur = int'(pwm_out) ^ pol;
            if (cur == 1 && prev == 0) begin
                n = 0;
                prev = cur;
                for (int j = 0; j < 4000; j++) begin
                    @(negedge clk);
                    n++;
                    cur = int'(pwm_out) ^ pol;
                    if (cur == 1 && prev == 0) begin
                        per = n;
                        break;
                    end
                    prev = cur;
                end
                break;
            end
            prev = cur;
        end
    endtask

    task automatic sweep_one(input int p, input int arr, input int cmp, input int pol);
        int per, hi, exp_hi, got_per;
        per = (arr + 1) << p;
        wr(A_CTRL, 0);
        wr(A_SETUP, (pol << 3) | p);
        wr(A_CTRL, 1);
        wr(A_RELOD, arr);
        wr(A_THRSH, cmp);
        wr(A_CTRL, 5);
        repeat (3) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 2 * per; i++) begin
            @(negedge clk);
            hi += int'(pwm_out) ^ pol;
        end
        exp_hi = (cmp >= arr) ? 0 : (2 * (arr - cmp)) << p;
        check("R8 high cycles in two periods", hi, exp_hi);
        if (cmp < arr) begin
            measure_period(pol, got_per);
            check("R7 period cycles", got_per, per);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int v;
        int pat[9];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        foreach (pat[k]) pat[k] = 0;
        rd(A_CTRL, v);  check("R1 ctrl", v, 0);
        rd(A_SETUP, v); check("R1 setup", v, 0);
        rd(A_RELOD, v); check("R1 reload", v, 0);
        rd(A_THRSH, v); check("R1 compare", v, 0);
        rd(A_FLAGS, v); check("R1 flags", v, 0);
        check("R1 output", int'(pwm_out), 0);

        // R3 reload/compare ignored while disabled
        wr(A_RELOD, 5);
        wr(A_THRSH, 2);
        @(negedge clk);
        rd(A_RELOD, v); check("R3 reload ignored", v, 0);
        rd(A_THRSH, v); check("R3 compare ignored", v, 0);
        rd(A_FLAGS, v); check("R3 no flag", v, 0);

        // R6 start while disabled ignored
        wr(A_CTRL, 4);
        rd(A_CTRL, v); check("R6 start without enable", v, 0);

        // R2 setup writable when disabled, R9 idle level follows polarity
        wr(A_SETUP, 'hA);
        rd(A_SETUP, v); check("R2 setup accepted", v, 'hA);
        check("R9 idle level inverted", int'(pwm_out), 1);
        wr(A_SETUP, 0);
        wr(A_CTRL, 1);
        wr(A_SETUP, 'hB);
        rd(A_SETUP, v); check("R2 setup ignored while enabled", v, 0);
        wr(A_CTRL, 4);
        rd(A_CTRL, v); check("R6 start needs bit0 in write", v, 0);
        rd(A_CTRL, v);
        wr(A_CTRL, 1);

        // R4 flag timing, R5 clearing
        wr(A_RELOD, 7);
        rd(A_FLAGS, v); check("R4 reload flag not yet", v, 0);
        rd(A_FLAGS, v); check("R4 reload flag one cycle later", v, 2);
        wr(A_THRSH, 3);
        @(negedge clk);
        rd(A_FLAGS, v); check("R4 both flags sticky", v, 3);
        wr(A_FCLR, 2);
        rd(A_FLAGS, v); check("R5 clear reload flag only", v, 1);
        wr(A_FCLR, 0);
        rd(A_FLAGS, v); check("R5 zero bits keep flags", v, 1);
        rd(A_FCLR, v); check("R5 clear reads zero", v, 0);
        wr(A_FCLR, 3);
        rd(A_FLAGS, v); check("R5 clear all", v, 0);

        // R6/R11: exact phase after start, compare update deferred to wrap
        wr(A_CTRL, 5);
        wr(A_THRSH, 0);
        pat = '{0, 0, 0, 1, 1, 1, 1, 0, 1};
        for (int j = 0; j < 9; j++) begin
            @(negedge clk);
            check("R11 deferred compare phase", int'(pwm_out), pat[j]);
        end
        rd(A_CTRL, v); check("R6 running readback", v, 5);

        // R10 stop and restart from zero
        wr(A_CTRL, 0);
        @(negedge clk);
        check("R10 idle after stop", int'(pwm_out), 0);
        rd(A_CTRL, v); check("R10 ctrl cleared", v, 0);
        wr(A_CTRL, 1);
        wr(A_CTRL, 5);
        @(negedge clk);
        check("R10 restart count zero", int'(pwm_out), 0);
        @(negedge clk);
        check("R10 restart count one", int'(pwm_out), 1);

        // R7 R8 R9 sweep over prescaler, reload, compare and polarity
        for (int p = 0; p < 3; p++) begin
            for (int ai = 0; ai < 3; ai++) begin
                for (int ci = 0; ci < 4; ci++) begin
                    int arr, cmp;
                    arr = (ai == 0) ? 1 : (ai == 1) ? 3 : 6;
                    cmp = (ci == 0) ? 0 : (ci == 1) ? arr / 2 : (ci == 2) ? arr : arr + 2;
                    sweep_one(p, arr, cmp, (p + ai + ci) % 2);
                end
            end
        end
        wr(A_CTRL, 0);
        @(negedge clk);
        check("R9 idle level after sweep", int'(pwm_out), (2 + 2 + 3) % 2);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule